// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state changes a small 32-bit in-order processor needs when it enters an exception. The core presents a one-cycle request with a 3-bit cause code. With it come the current program counter, the 3-bit interrupt-enable status register, a normal vector base, a debug vector base and a remap control bit. On the next clock edge the block returns three results. The first is a write strobe and data for one of two link registers: the exception-address register or the breakpoint-address register. The second is the new interrupt-enable value. The third is the handler address for the program counter.

Causes fall into two classes. Bus errors, divide-by-zero, external interrupts and system calls form the normal class. Breakpoints and watchpoints form the debug class. Each class has its own link register and its own saved-enable bit. Normal-class causes vector through the normal base unless remap is set; in that case they use the debug base. Debug-class causes always use the debug base.

Each cause owns a 32-byte slot in a 256-byte-aligned table, so the handler address is assembled from bits and needs no adder. A code the block does not handle raises a fatal flag and leaves every output register unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Codes 2, 4, 5, 6 and 7 (instruction bus error, data bus error, divide-by-zero, interrupt, system call) are the normal class. A request with one of them pulses `ea_we_o` and loads `link_o` with `pc_i`, while `ba_we_o` stays low.
- R2: Codes 1 (breakpoint) and 3 (watchpoint) are the debug class. A request with one of them pulses `ba_we_o` and loads `link_o` with `pc_i`, while `ea_we_o` stays low.
- R3: On a normal-class entry, bit 1 of `ien_o` (saved normal enable) becomes 1 if bit 0 of `ien_i` (global enable) is 1. Otherwise it keeps its value from `ien_i`. Bit 2 passes through from `ien_i`.
- R4: On a debug-class entry, bit 2 of `ien_o` (saved debug enable) becomes 1 if bit 0 of `ien_i` is 1. Otherwise it keeps its value from `ien_i`. Bit 1 passes through from `ien_i`.
- R5: Every handled entry pulses `vec_take_o` and clears bit 0 of `ien_o`.
- R6: `pc_o` takes bits 31:8 from the selected base, bits 7:5 from the code and bits 4:0 as zero. The low byte of either base has no effect.
- R7: Normal-class entries select `base_norm_i` when `remap_i` is 0 and `base_dbg_i` when `remap_i` is 1.
- R8: Debug-class entries select `base_dbg_i` regardless of `remap_i`.
- R9: A request with code 0 pulses `fatal_o` and raises no write strobe. `link_o`, `ien_o` and `pc_o` keep their previous values.
- R10: Results appear on the first rising edge after the request, and every strobe is high for exactly that one cycle. Without a request, the strobes stay low and the data outputs hold.
- R11: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle exception request |
| code_i | input | 3 | Exception cause code |
| pc_i | input | 32 | Program counter of the faulting instruction |
| ien_i | input | 3 | Current enable register: bit 0 global, bit 1 saved normal, bit 2 saved debug |
| base_norm_i | input | 32 | Normal vector table base (256-byte aligned) |
| base_dbg_i | input | 32 | Debug vector table base (256-byte aligned) |
| remap_i | input | 1 | Send normal-class vectors through the debug base |
| ea_we_o | output | 1 | Write strobe for the exception-address register |
| ba_we_o | output | 1 | Write strobe for the breakpoint-address register |
| link_o | output | 32 | Return address to write into the selected link register |
| vec_take_o | output | 1 | Strobe: load `pc_o` into the PC and `ien_o` into the enable register |
| ien_o | output | 3 | New enable register value |
| pc_o | output | 32 | Handler address |
| fatal_o | output | 1 | Unsupported cause code was requested |

## Verification
Every result, strobe and data alike, is due on the first rising edge after the cycle in which `req_i` is high. The bench drives each request on a falling edge and removes it on the next falling edge, then samples all outputs there, half a cycle after the only edge that can change them. One cycle later it samples again, checking that the strobes have dropped and the data has held. For unsupported codes and idle cycles, the bench compares the held data outputs against the values it recorded from the preceding handled entry.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W     = 3;
  localparam int SLOT_SHIFT = 5;   // 32-byte vector slots
  localparam int IEN_W      = 3;
  localparam int IEN_IE     = 0;   // global enable
  localparam int IEN_EIE    = 1;   // saved enable, normal class
  localparam int IEN_BIE    = 2;   // saved enable, debug class

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_BRK   = 3'd1,
    EXC_IBUS  = 3'd2,
    EXC_WATCH = 3'd3,
    EXC_DBUS  = 3'd4,
    EXC_DIV0  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_SCALL = 3'd7
  } exc_code_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_NORM = 2'd1,
    CLS_DBG  = 2'd2
  } exc_class_e;

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output exc_class_e        cls
);

  always_comb begin
    unique case (exc_code_e'(code))
      EXC_BRK, EXC_WATCH:                         cls = CLS_DBG;
      EXC_IBUS, EXC_DBUS, EXC_DIV0, EXC_IRQ,
      EXC_SCALL:                                  cls = CLS_NORM;
      default:                                    cls = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/exc_ien_update.sv
module exc_ien_update
  import exc_entry_pkg::*;
(
  input  exc_class_e       cls,
  input  logic [IEN_W-1:0] ien_cur,
  output logic [IEN_W-1:0] ien_nxt
);

  always_comb begin
    ien_nxt = ien_cur;
    if (cls == CLS_NORM) begin
      ien_nxt[IEN_EIE] = ien_cur[IEN_EIE] | ien_cur[IEN_IE];
    end else if (cls == CLS_DBG) begin
      ien_nxt[IEN_BIE] = ien_cur[IEN_BIE] | ien_cur[IEN_IE];
    end
    ien_nxt[IEN_IE] = 1'b0;
  end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  exc_class_e        cls,
  input  logic              remap,
  input  logic [AW-1:0]     base_norm,
  input  logic [AW-1:0]     base_dbg,
  input  logic [CODE_W-1:0] code,
  output logic [AW-1:0]     vec
);

  localparam int            LOW_W    = CODE_W + SLOT_SHIFT;
  localparam logic [AW-1:0] LOW_MASK = {{(AW-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic          use_dbg;
  logic [AW-1:0] base_sel;

  always_comb begin
    use_dbg  = (cls == CLS_DBG) || remap;
    base_sel = use_dbg ? base_dbg : base_norm;
    vec      = (base_sel & ~LOW_MASK) | (AW'(code) << SLOT_SHIFT);
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [2:0]    code_i,
  input  logic [AW-1:0] pc_i,
  input  logic [2:0]    ien_i,
  input  logic [AW-1:0] base_norm_i,
  input  logic [AW-1:0] base_dbg_i,
  input  logic          remap_i,
  output logic          ea_we_o,
  output logic          ba_we_o,
  output logic [AW-1:0] link_o,
  output logic          vec_take_o,
  output logic [2:0]    ien_o,
  output logic [AW-1:0] pc_o,
  output logic          fatal_o
);

  exc_class_e       cls;
  logic [AW-1:0]    vec_d;
  logic [IEN_W-1:0] ien_d;
  logic             take_d, ea_we_d, ba_we_d, fatal_d;

  exc_classify u_cls (
    .code (code_i),
    .cls  (cls)
  );

  exc_ien_update u_ien (
    .cls     (cls),
    .ien_cur (ien_i),
    .ien_nxt (ien_d)
  );

  exc_vector_gen #(.AW(AW)) u_vec (
    .cls       (cls),
    .remap     (remap_i),
    .base_norm (base_norm_i),
    .base_dbg  (base_dbg_i),
    .code      (code_i),
    .vec       (vec_d)
  );

  // next-state
  always_comb begin
    take_d  = req_i && (cls != CLS_NONE);
    ea_we_d = req_i && (cls == CLS_NORM);
    ba_we_d = req_i && (cls == CLS_DBG);
    fatal_d = req_i && (cls == CLS_NONE);
  end

  // strobes: one cycle per request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_we_o    <= 1'b0;
      ba_we_o    <= 1'b0;
      vec_take_o <= 1'b0;
      fatal_o    <= 1'b0;
    end else begin
      ea_we_o    <= ea_we_d;
      ba_we_o    <= ba_we_d;
      vec_take_o <= take_d;
      fatal_o    <= fatal_d;
    end
  end

  // data: loaded only on a handled entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_o <= '0;
      ien_o  <= '0;
      pc_o   <= '0;
    end else if (take_d) begin
      link_o <= pc_i;
      ien_o  <= ien_d;
      pc_o   <= vec_d;
    end
  end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic [2:0]    code_i,
  input logic [AW-1:0] pc_i,
  input logic [2:0]    ien_i,
  input logic [AW-1:0] base_norm_i,
  input logic [AW-1:0] base_dbg_i,
  input logic          remap_i,
  input logic          ea_we_o,
  input logic          ba_we_o,
  input logic [AW-1:0] link_o,
  input logic          vec_take_o,
  input logic [2:0]    ien_o,
  input logic [AW-1:0] pc_o,
  input logic          fatal_o
);

  logic is_norm, is_dbg;
  assign is_norm = (code_i == 3'd2) || (code_i == 3'd4) || (code_i == 3'd5) ||
                   (code_i == 3'd6) || (code_i == 3'd7);
  assign is_dbg  = (code_i == 3'd1) || (code_i == 3'd3);

  AST_NORM_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_norm |=> ea_we_o && !ba_we_o && link_o == $past(pc_i)); // R1

  AST_DBG_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_dbg |=> ba_we_o && !ea_we_o && link_o == $past(pc_i)); // R2

  AST_NORM_EIE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_norm && ien_i[0] |=> ien_o[1]); // R3

  AST_DBG_BIE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_dbg && ien_i[0] |=> ien_o[2]); // R4

  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && (is_norm || is_dbg) |=> vec_take_o && !ien_o[0]); // R5

  AST_SLOT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take_o |-> pc_o[4:0] == 5'd0); // R6

  AST_NORM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_norm && !remap_i |=> pc_o[AW-1:8] == $past(base_norm_i[AW-1:8])); // R7

  AST_DBG_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && is_dbg |=> pc_o[AW-1:8] == $past(base_dbg_i[AW-1:8])); // R8

  AST_FATAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_i && code_i == 3'd0 |=> fatal_o && !ea_we_o && !ba_we_o && !vec_take_o &&
                                $stable(pc_o) && $stable(link_o) && $stable(ien_o)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !ea_we_o && !ba_we_o && !vec_take_o && !fatal_o && $stable(pc_o)); // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ea_we_o, ba_we_o, fatal_o})); // R10

endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .code_i(code_i), .pc_i(pc_i),
  .ien_i(ien_i), .base_norm_i(base_norm_i), .base_dbg_i(base_dbg_i),
  .remap_i(remap_i), .ea_we_o(ea_we_o), .ba_we_o(ba_we_o), .link_o(link_o),
  .vec_take_o(vec_take_o), .ien_o(ien_o), .pc_o(pc_o), .fatal_o(fatal_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i;
  logic [2:0]  code_i;
  logic [31:0] pc_i;
  logic [2:0]  ien_i;
  logic [31:0] base_norm_i, base_dbg_i;
  logic        remap_i;
  logic        ea_we_o, ba_we_o, vec_take_o, fatal_o;
  logic [31:0] link_o, pc_o;
  logic [2:0]  ien_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz

  exc_entry_ctrl #(.AW(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .code_i(code_i), .pc_i(pc_i),
    .ien_i(ien_i), .base_norm_i(base_norm_i), .base_dbg_i(base_dbg_i),
    .remap_i(remap_i), .ea_we_o(ea_we_o), .ba_we_o(ba_we_o), .link_o(link_o),
    .vec_take_o(vec_take_o), .ien_o(ien_o), .pc_o(pc_o), .fatal_o(fatal_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slot(input logic [31:0] base, input logic [2:0] code);
    return {base[31:8], code, 5'b00000};
  endfunction

  // request on a falling edge, result sampled on the next falling edge
  task automatic fire(input logic [2:0] c, input logic [31:0] pc, input logic [2:0] ie,
                      input logic rm);
    @(negedge clk);
    req_i = 1'b1; code_i = c; pc_i = pc; ien_i = ie; remap_i = rm;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 strobes", {28'd0, ea_we_o, ba_we_o, vec_take_o, fatal_o}, 32'd0);
    chk("R11 link", link_o, 32'd0);
    chk("R11 pc", pc_o, 32'd0);
    chk("R11 ien", {29'd0, ien_o}, 32'd0);
  endtask

  task automatic t_normal;
    logic [2:0] codes [5] = '{3'd2, 3'd4, 3'd5, 3'd6, 3'd7};
    foreach (codes[i]) begin
      fire(codes[i], 32'h4000_0100 + 32'(i * 4), 3'b101, 1'b0);
      chk("R1 ea_we", {31'd0, ea_we_o}, 32'd1);
      chk("R1 ba_we", {31'd0, ba_we_o}, 32'd0);
      chk("R1 link", link_o, 32'h4000_0100 + 32'(i * 4));
      chk("R3 ien", {29'd0, ien_o}, 32'b110);
      chk("R5 take", {31'd0, vec_take_o}, 32'd1);
      chk("R7 R6 pc", pc_o, slot(base_norm_i, codes[i]));
      @(negedge clk);
      chk("R10 pulse", {28'd0, ea_we_o, ba_we_o, vec_take_o, fatal_o}, 32'd0);
    end
  endtask

  task automatic t_normal_ie0;
    fire(3'd6, 32'h10, 3'b000, 1'b0);
    chk("R3 eie stays 0", {29'd0, ien_o}, 32'b000);
    fire(3'd6, 32'h14, 3'b010, 1'b0);
    chk("R3 eie kept", {29'd0, ien_o}, 32'b010);
    fire(3'd2, 32'h18, 3'b100, 1'b0);
    chk("R3 bie passes", {29'd0, ien_o}, 32'b100);
  endtask

  task automatic t_remap;
    fire(3'd7, 32'h2222_0000, 3'b001, 1'b1);
    chk("R7 remap pc", pc_o, slot(base_dbg_i, 3'd7));
    chk("R1 remap ea", {31'd0, ea_we_o}, 32'd1);
  endtask

  task automatic t_debug;
    for (int r = 0; r < 2; r++) begin
      fire(3'd1, 32'h8000_0040, 3'b001, r[0]);
      chk("R2 ba_we", {31'd0, ba_we_o}, 32'd1);
      chk("R2 ea_we", {31'd0, ea_we_o}, 32'd0);
      chk("R2 link", link_o, 32'h8000_0040);
      chk("R4 ien", {29'd0, ien_o}, 32'b100);
      chk("R8 pc", pc_o, slot(base_dbg_i, 3'd1));
      fire(3'd3, 32'h8000_0080, 3'b011, r[0]);
      chk("R4 eie passes", {29'd0, ien_o}, 32'b110);
      chk("R8 watch pc", pc_o, slot(base_dbg_i, 3'd3));
    end
    fire(3'd3, 32'h8000_00C0, 3'b100, 1'b0);
    chk("R4 bie kept", {29'd0, ien_o}, 32'b100);
    fire(3'd1, 32'h8000_00C4, 3'b010, 1'b0);
    chk("R4 bie stays 0", {29'd0, ien_o}, 32'b010);
  endtask

  task automatic t_base_low;
    base_norm_i = 32'hABCD_EFFF;
    fire(3'd5, 32'h1, 3'b001, 1'b0);
    chk("R6 low byte ignored", pc_o, 32'hABCD_EFA0);
    base_norm_i = 32'h0001_2300;
  endtask

  task automatic t_unsupported;
    logic [31:0] l0, p0; logic [2:0] i0;
    fire(3'd4, 32'h5555_0004, 3'b001, 1'b0);
    l0 = link_o; p0 = pc_o; i0 = ien_o;
    fire(3'd0, 32'h9999_9999, 3'b111, 1'b1);
    chk("R9 fatal", {31'd0, fatal_o}, 32'd1);
    chk("R9 no strobes", {29'd0, ea_we_o, ba_we_o, vec_take_o}, 32'd0);
    chk("R9 link held", link_o, l0);
    chk("R9 pc held", pc_o, p0);
    chk("R9 ien held", {29'd0, ien_o}, {29'd0, i0});
    @(negedge clk);
    chk("R10 fatal pulse", {31'd0, fatal_o}, 32'd0);
  endtask

  task automatic t_idle;
    logic [31:0] p0;
    p0 = pc_o;
    code_i = 3'd7; pc_i = 32'hDEAD_0000; ien_i = 3'b001;
    base_norm_i = 32'hFFFF_FF00;
    repeat (3) @(negedge clk);
    chk("R10 idle strobes", {28'd0, ea_we_o, ba_we_o, vec_take_o, fatal_o}, 32'd0);
    chk("R10 idle pc held", pc_o, p0);
    base_norm_i = 32'h0001_2300;
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_i = 1'b0; code_i = '0; pc_i = '0; ien_i = '0;
    base_norm_i = 32'h0001_2300; base_dbg_i = 32'h0ABC_0000; remap_i = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_normal;
    t_normal_ie0;
    t_remap;
    t_debug;
    t_base_low;
    t_unsupported;
    t_idle;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule